// File: doc/BRIEF.md
# Descriptor Ring Poll Scheduler

This block decides when the DMA engine of a network controller re-reads its current receive and transmit ring descriptors, so it can see whether the host has handed them over. It is idle whenever the channel is busy. Otherwise it counts down a poll interval. When the interval runs out, when a frame completes, or when software demands a poll, it issues an ordered series of descriptor-word reads on a simple request/acknowledge read port.

A receive poll reads the receive descriptor's high (status/ownership) word and then its low word. A transmit poll does the same for the transmit descriptor, in a separate bus tenure. The enable bits, the transmit-poll disable bit and the ownership flags supplied by the surrounding controller decide which parts of a poll run. The interval can be reprogrammed, but only inside a short configuration window. The block keeps copies of the last descriptor words it found handed over to the controller.

Top module: `desc_poll_sched`

## Requirements
- R1: A poll reads with `rd_sel` codes in a fixed order: 0 (receive high word), then 1 (receive low word), then 2 (transmit high word), then 3 (transmit low word). Either pair may be absent. `rd_req` stays high with a stable `rd_sel` until `rd_ack`. It stays high between the two words of one descriptor and drops for at least one cycle between the receive and transmit tenures.
- R2: No poll starts while `chan_busy` is high. The countdown pauses, and a trigger that arrives during that time is serviced once `chan_busy` falls.
- R3: A timer or demand poll includes the receive pair only when `rx_en`=1 and the controller lacks ownership of either the current or the next receive descriptor. With `rx_en`=0 the receive pair is never read.
- R4: With `ring_single`=1 the next-receive ownership flag is ignored.
- R5: Frame-received and frame-transmitted pulses trigger only the transmit pair. That pair needs `tx_en`=1, `tx_poll_dis`=0 and `own_tx_cur`=0, and the same holds for timer expiry.
- R6: A `poll_demand` pulse cancels the countdown and polls at once, receive pair first when R3 allows it. Its transmit pair needs `tx_en`=1 and `own_tx_cur`=0 and overrides `tx_poll_dis`.
- R7: A demand that arrives while a poll is in progress is held and is serviced as a new poll after the engine returns to its countdown.
- R8: After reset the interval is 65,536 cycles. The next timer poll raises `rd_req` exactly that many clock edges after the edge that accepted the last read of a poll. An interval value of 0 also means 65,536.
- R9: An `ivl_wr` write takes effect only when it falls after `init_req` followed by `init_done`, and before `start_run`. Other writes are ignored.
- R10: A descriptor pair is stored in the `*_w1`/`*_w0` outputs only when bit DW-1 of its high word is 1 (handed to the controller). Otherwise the stored copies are left unchanged.
- R11: Under reset `rd_req` is low and all stored descriptor words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_busy | input | 1 | Channel or pre/post frame work in progress |
| rx_en | input | 1 | Receive enabled |
| tx_en | input | 1 | Transmit enabled |
| tx_poll_dis | input | 1 | Disable timer/event transmit polls |
| ring_single | input | 1 | Receive ring holds one descriptor |
| own_rx_cur | input | 1 | Controller owns current receive descriptor |
| own_rx_nxt | input | 1 | Controller owns next receive descriptor |
| own_tx_cur | input | 1 | Controller owns current transmit descriptor |
| poll_demand | input | 1 | Software poll demand pulse |
| rx_frame_done | input | 1 | Frame received pulse |
| tx_frame_done | input | 1 | Frame transmitted pulse |
| init_req | input | 1 | Initialisation requested pulse |
| init_done | input | 1 | Initialisation done pulse |
| start_run | input | 1 | Start pulse, closes the config window |
| ivl_wr | input | 1 | Interval write strobe |
| ivl_wdata | input | IVL_W | Interval value, 0 means 2^IVL_W |
| rd_req | output | 1 | Descriptor read request, held through a tenure |
| rd_sel | output | 2 | Which descriptor word is requested |
| rd_ack | input | 1 | Read accepted, data valid |
| rd_data | input | DW | Read data |
| rx_w1 | output | DW | Stored receive high word |
| rx_w0 | output | DW | Stored receive low word |
| tx_w1 | output | DW | Stored transmit high word |
| tx_w0 | output | DW | Stored transmit low word |

## Verification
A demand pulse sampled at one edge becomes pending at that edge, and `rd_req` rises at the next edge. Each word completes on its acknowledge edge, and the receive-to-transmit gap costs one cycle. The stored words change at the edge that accepts the low word. A timer poll raises `rd_req` exactly the interval count of edges after the last acknowledge. The interval checks count those edges one by one, sampling at the falling edge. The order and ownership checks wait a fixed settle window longer than the slowest four-word poll and then compare the logged sequence of accepted `rd_sel` codes and tenure numbers.

// File: rtl/poll_pkg.sv
// Shared types for the descriptor poll scheduler.
// Assumes: word selector codes are decoded by the bus-master read port.
package poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_HI,
        ST_RX_LO,
        ST_GAP,
        ST_TX_HI,
        ST_TX_LO
    } poll_st_e;

    typedef enum logic [1:0] {
        CFG_LOCKED,
        CFG_INIT_WAIT,
        CFG_OPEN
    } cfg_st_e;

    localparam logic [1:0] SEL_RX_HI = 2'd0;
    localparam logic [1:0] SEL_RX_LO = 2'd1;
    localparam logic [1:0] SEL_TX_HI = 2'd2;
    localparam logic [1:0] SEL_TX_LO = 2'd3;
endpackage

// File: rtl/poll_interval_cfg.sv
// Holds the poll interval and the window in which it may be rewritten.
// Assumes: init_req, init_done and start_run are single-cycle pulses.
// The window opens on init_done after init_req and closes on start_run.
module poll_interval_cfg
    import poll_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             init_done,
    input  logic             start_run,
    input  logic             ivl_wr,
    input  logic [IVL_W-1:0] ivl_wdata,
    output logic [IVL_W-1:0] ivl_q
);
    cfg_st_e cfg_st;

    // Track the configuration window (start has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_st <= CFG_LOCKED;
        end else if (start_run) begin
            cfg_st <= CFG_LOCKED;
        end else if (init_req) begin
            cfg_st <= CFG_INIT_WAIT;
        end else if (init_done && cfg_st == CFG_INIT_WAIT) begin
            cfg_st <= CFG_OPEN;
        end
    end

    // Accept an interval write only while the window is open (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else if (ivl_wr && cfg_st == CFG_OPEN) begin
            ivl_q <= ivl_wdata;
        end
    end
endmodule

// File: rtl/poll_timer.sv
// Poll interval down-counter.
// Assumes: an interval of 0 stands for 2^IVL_W cycles; load has priority over run.
// hit is high in the run cycle in which the count reaches its last step.
module poll_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] ivl_q,
    input  logic             load,
    input  logic             run,
    output logic             hit
);
    localparam int CNT_W = IVL_W + 1;

    logic [CNT_W-1:0] ivl_eff;
    logic [CNT_W-1:0] cnt;

    // Expand the stored interval, zero meaning the full range (R8).
    always_comb begin
        if (ivl_q == '0) ivl_eff = CNT_W'(1) << IVL_W;
        else             ivl_eff = {1'b0, ivl_q};
    end

    assign hit = run && (cnt == CNT_W'(1));

    // Reload or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ivl_eff;
        end else if (load) begin
            cnt <= ivl_eff;
        end else if (run && cnt != CNT_W'(1)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/poll_seq.sv
// Poll sequencer: latches triggers, decides which descriptor pairs to read
// and walks the ordered reads on the request/acknowledge port.
// Assumes: rd_ack is asserted only while rd_req is high.
module poll_seq
    import poll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_busy,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic       tx_poll_dis,
    input  logic       ring_single,
    input  logic       own_rx_cur,
    input  logic       own_rx_nxt,
    input  logic       own_tx_cur,
    input  logic       poll_demand,
    input  logic       rx_frame_done,
    input  logic       tx_frame_done,
    input  logic       timer_hit,
    input  logic       rd_ack,
    output logic       timer_load,
    output logic       timer_run,
    output logic       rd_req,
    output logic [1:0] rd_sel
);
    poll_st_e state;
    logic     dmd_pend;
    logic     evt_pend;
    logic     tx_plan;
    logic     idle_ok;
    logic     dispatch;
    logic     rx_want;
    logic     tx_want;
    logic     rx_unowned;

    assign idle_ok   = (state == ST_IDLE) && !chan_busy;            // R2
    assign dispatch  = idle_ok && (timer_hit || dmd_pend || evt_pend);
    assign timer_run = idle_ok;
    assign timer_load = (state != ST_IDLE) || dispatch;

    // Receive ownership gap; next descriptor ignored on a single ring (R3, R4).
    assign rx_unowned = !own_rx_cur || (!ring_single && !own_rx_nxt);
    assign rx_want    = rx_en && rx_unowned && (timer_hit || dmd_pend);
    // Demand overrides the disable bit; events and timer do not (R5, R6).
    assign tx_want    = tx_en && !own_tx_cur &&
                        (dmd_pend || (!tx_poll_dis && (timer_hit || evt_pend)));

    // Sticky demand and frame-event flags, consumed at dispatch (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmd_pend <= 1'b0;
            evt_pend <= 1'b0;
        end else begin
            dmd_pend <= poll_demand || (dmd_pend && !dispatch);
            evt_pend <= rx_frame_done || tx_frame_done || (evt_pend && !dispatch);
        end
    end

    // Read sequence: receive pair, gap, transmit pair (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tx_plan <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (dispatch) begin
                        tx_plan <= tx_want;
                        if (rx_want)      state <= ST_RX_HI;
                        else if (tx_want) state <= ST_TX_HI;
                    end
                end
                ST_RX_HI: if (rd_ack) state <= ST_RX_LO;
                ST_RX_LO: if (rd_ack) state <= tx_plan ? ST_GAP : ST_IDLE;
                ST_GAP:   state <= ST_TX_HI;
                ST_TX_HI: if (rd_ack) state <= ST_TX_LO;
                ST_TX_LO: if (rd_ack) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Drive the read port from the state.
    always_comb begin
        rd_req = 1'b1;
        rd_sel = SEL_RX_HI;
        case (state)
            ST_RX_HI: rd_sel = SEL_RX_HI;
            ST_RX_LO: rd_sel = SEL_RX_LO;
            ST_TX_HI: rd_sel = SEL_TX_HI;
            ST_TX_LO: rd_sel = SEL_TX_LO;
            default:  rd_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/poll_capture.sv
// Stores one descriptor's two words when the controller is found to own it.
// Assumes: the high word is read before the low word; bit DW-1 of the
// high word set means the descriptor was handed to the controller.
module poll_capture #(
    parameter int         DW     = 32,
    parameter logic [1:0] HI_SEL = 2'd0,
    parameter logic [1:0] LO_SEL = 2'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rd_ack,
    input  logic [1:0]    rd_sel,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] w1_q,
    output logic [DW-1:0] w0_q
);
    logic [DW-1:0] hi_tmp;
    logic          take_hi;
    logic          take_lo;

    assign take_hi = rd_req && rd_ack && (rd_sel == HI_SEL);
    assign take_lo = rd_req && rd_ack && (rd_sel == LO_SEL);

    // Hold the high word until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_tmp <= '0;
        else if (take_hi) hi_tmp <= rd_data;
    end

    // Commit the pair only from an owned descriptor (R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w1_q <= '0;
            w0_q <= '0;
        end else if (take_lo && hi_tmp[DW-1]) begin
            w1_q <= hi_tmp;
            w0_q <= rd_data;
        end
    end
endmodule

// File: rtl/desc_poll_sched.sv
// Descriptor ring poll scheduler top: interval config, timer, sequencer
// and one capture unit per ring.
// Assumes: ownership flags come from the controller's descriptor logic.
module desc_poll_sched
    import poll_pkg::*;
#(
    parameter int IVL_W = 16,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_busy,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             tx_poll_dis,
    input  logic             ring_single,
    input  logic             own_rx_cur,
    input  logic             own_rx_nxt,
    input  logic             own_tx_cur,
    input  logic             poll_demand,
    input  logic             rx_frame_done,
    input  logic             tx_frame_done,
    input  logic             init_req,
    input  logic             init_done,
    input  logic             start_run,
    input  logic             ivl_wr,
    input  logic [IVL_W-1:0] ivl_wdata,
    output logic             rd_req,
    output logic [1:0]       rd_sel,
    input  logic             rd_ack,
    input  logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    rx_w1,
    output logic [DW-1:0]    rx_w0,
    output logic [DW-1:0]    tx_w1,
    output logic [DW-1:0]    tx_w0
);
    localparam int N_RING = 2;

    logic [IVL_W-1:0] ivl_q;
    logic             timer_load;
    logic             timer_run;
    logic             timer_hit;
    logic [DW-1:0]    w1_arr [N_RING];
    logic [DW-1:0]    w0_arr [N_RING];

    poll_interval_cfg #(.IVL_W(IVL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_req  (init_req),
        .init_done (init_done),
        .start_run (start_run),
        .ivl_wr    (ivl_wr),
        .ivl_wdata (ivl_wdata),
        .ivl_q     (ivl_q)
    );

    poll_timer #(.IVL_W(IVL_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ivl_q (ivl_q),
        .load  (timer_load),
        .run   (timer_run),
        .hit   (timer_hit)
    );

    poll_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .chan_busy     (chan_busy),
        .rx_en         (rx_en),
        .tx_en         (tx_en),
        .tx_poll_dis   (tx_poll_dis),
        .ring_single   (ring_single),
        .own_rx_cur    (own_rx_cur),
        .own_rx_nxt    (own_rx_nxt),
        .own_tx_cur    (own_tx_cur),
        .poll_demand   (poll_demand),
        .rx_frame_done (rx_frame_done),
        .tx_frame_done (tx_frame_done),
        .timer_hit     (timer_hit),
        .rd_ack        (rd_ack),
        .timer_load    (timer_load),
        .timer_run     (timer_run),
        .rd_req        (rd_req),
        .rd_sel        (rd_sel)
    );

    // One capture unit per ring: index 0 receive, index 1 transmit.
    for (genvar g = 0; g < N_RING; g++) begin : g_cap
        poll_capture #(
            .DW     (DW),
            .HI_SEL (2'(2 * g)),
            .LO_SEL (2'(2 * g + 1))
        ) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_req  (rd_req),
            .rd_ack  (rd_ack),
            .rd_sel  (rd_sel),
            .rd_data (rd_data),
            .w1_q    (w1_arr[g]),
            .w0_q    (w0_arr[g])
        );
    end

    assign rx_w1 = w1_arr[0];
    assign rx_w0 = w0_arr[0];
    assign tx_w1 = w1_arr[1];
    assign tx_w0 = w0_arr[1];
endmodule

// File: rtl/desc_poll_sched_chk.sv
// Protocol checker for the poll scheduler, bound to the top module.
// Assumes: synchronous active-low reset; all checks are disabled under reset.
module desc_poll_sched_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chan_busy,
    input logic          rx_en,
    input logic          rd_req,
    input logic [1:0]    rd_sel,
    input logic          rd_ack,
    input logic [DW-1:0] rx_w1,
    input logic [DW-1:0] tx_w1
);
    // R1
    rx_pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_sel == 2'd0) |=> (rd_req && rd_sel == 2'd1));
    // R1
    tenure_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_sel == 2'd1) |=> !rd_req);
    // R1
    tx_pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_sel == 2'd2) |=> (rd_req && rd_sel == 2'd3));
    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_sel)));
    // R2
    busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && chan_busy) |=> !rd_req);
    // R3
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !rx_en) |=> !(rd_req && !rd_sel[1]));
    // R10
    rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_w1) |-> ($past(rd_req && rd_ack && rd_sel == 2'd1) && rx_w1[DW-1]));
    // R10
    tx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_w1) |-> ($past(rd_req && rd_ack && rd_sel == 2'd3) && tx_w1[DW-1]));
endmodule

bind desc_poll_sched desc_poll_sched_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_busy (chan_busy),
    .rx_en     (rx_en),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel),
    .rd_ack    (rd_ack),
    .rx_w1     (rx_w1),
    .tx_w1     (tx_w1)
);

// File: tb/desc_poll_sched_bench.sv
// Self-checking bench for the descriptor poll scheduler.
module desc_poll_sched_bench;
    localparam int IVL_W = 16;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_busy = 0, rx_en = 0, tx_en = 0, tx_poll_dis = 0, ring_single = 0;
    logic own_rx_cur = 1, own_rx_nxt = 1, own_tx_cur = 1;
    logic poll_demand = 0, rx_frame_done = 0, tx_frame_done = 0;
    logic init_req = 0, init_done = 0, start_run = 0, ivl_wr = 0;
    logic [IVL_W-1:0] ivl_wdata = '0;
    logic rd_req;
    logic [1:0] rd_sel;
    logic rd_ack;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] rx_w1, rx_w0, tx_w1, tx_w0;
    logic [DW-1:0] mem_w [4] = '{default: '0};

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    desc_poll_sched #(.IVL_W(IVL_W), .DW(DW)) u_desc_poll_sched (
        .clk(clk), .rst_n(rst_n), .chan_busy(chan_busy), .rx_en(rx_en), .tx_en(tx_en),
        .tx_poll_dis(tx_poll_dis), .ring_single(ring_single), .own_rx_cur(own_rx_cur),
        .own_rx_nxt(own_rx_nxt), .own_tx_cur(own_tx_cur), .poll_demand(poll_demand),
        .rx_frame_done(rx_frame_done), .tx_frame_done(tx_frame_done), .init_req(init_req),
        .init_done(init_done), .start_run(start_run), .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack), .rd_data(rd_data),
        .rx_w1(rx_w1), .rx_w0(rx_w0), .tx_w1(tx_w1), .tx_w0(tx_w0)
    );

    // Memory model: acknowledge one cycle after each request cycle.
    always @(posedge clk) begin
        if (!rst_n) rd_ack <= 1'b0;
        else        rd_ack <= rd_req && !rd_ack;
    end
    assign rd_data = mem_w[rd_sel];

    // Read log: accepted selector codes and the tenure each belongs to.
    logic [1:0] log_sel [512];
    int         log_ten [512];
    int         nlog = 0;
    int         tenure = 0;
    logic       prev_req = 1'b0;
    always @(posedge clk) begin
        prev_req <= rd_req;
        if (rd_req && !prev_req) tenure <= tenure + 1;
        if (rd_req && rd_ack) begin
            log_sel[nlog % 512] <= rd_sel;
            log_ten[nlog % 512] <= tenure + ((rd_req && !prev_req) ? 1 : 0);
            nlog <= nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_demand();
        @(negedge clk) poll_demand = 1'b1;
        @(negedge clk) poll_demand = 1'b0;
    endtask

    task automatic set_own(input logic rc, input logic rn, input logic tc);
        own_rx_cur = rc; own_rx_nxt = rn; own_tx_cur = tc;
    endtask

    // Compare reads logged since base against the expected pairs.
    task automatic chk_seq(input int base, input bit exp_rx, input bit exp_tx, input string req);
        int n_exp = (exp_rx ? 2 : 0) + (exp_tx ? 2 : 0);
        int k = 0;
        chk(nlog - base == n_exp, req, "read count", nlog - base, n_exp);
        if (nlog - base == n_exp) begin
            if (exp_rx) begin
                chk(log_sel[base % 512] == 2'd0 && log_sel[(base + 1) % 512] == 2'd1, req,
                    "rx word order", log_sel[(base + 1) % 512], 1);
                k = 2;
            end
            if (exp_tx)
                chk(log_sel[(base + k) % 512] == 2'd2 && log_sel[(base + k + 1) % 512] == 2'd3,
                    req, "tx word order", log_sel[(base + k + 1) % 512], 3);
            if (exp_rx && exp_tx)
                chk(log_ten[base % 512] == log_ten[(base + 1) % 512] &&
                    log_ten[(base + 2) % 512] != log_ten[(base + 1) % 512],
                    "R1", "separate tenures", log_ten[(base + 2) % 512], log_ten[(base + 1) % 512] + 1);
        end
    endtask

    // Issue a demand, let that poll end, then count edges to the timer poll.
    task automatic measure_interval(input int exp_n, input string req);
        int base = nlog;
        int n = 0;
        set_own(0, 0, 0);
        pulse_demand();
        while (nlog < base + 4) @(negedge clk);
        while (!rd_req && n < 70000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, req, "timer poll interval", n, exp_n);
        base = nlog;
        repeat (16) @(negedge clk);
        set_own(1, 1, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic write_ivl(input logic [IVL_W-1:0] v);
        @(negedge clk) begin ivl_wr = 1'b1; ivl_wdata = v; end
        @(negedge clk) ivl_wr = 1'b0;
    endtask

    task automatic pulse_cfg(input int which);
        @(negedge clk);
        case (which)
            0: init_req = 1'b1;
            1: init_done = 1'b1;
            default: start_run = 1'b1;
        endcase
        @(negedge clk) begin init_req = 1'b0; init_done = 1'b0; start_run = 1'b0; end
    endtask

    // Vector table: [10]rx_en [9]tx_en [8]tx_poll_dis [7]ring_single [6]own_rx_cur
    // [5]own_rx_nxt [4]own_tx_cur [3:2]trigger (0 demand, 1 rx frame, 2 tx frame)
    // [1]expect rx pair [0]expect tx pair
    localparam logic [10:0] VEC [11] = '{
        11'b110_0000_0011,   // R3 nothing owned, demand
        11'b110_0100_0011,   // R4 next receive unowned, ring of many
        11'b110_1100_0001,   // R4 same, single ring ignores next
        11'b010_0000_0001,   // R3 receive disabled
        11'b110_0001_0010,   // R6 transmit owned, receive only
        11'b111_0000_0011,   // R6 demand overrides transmit disable
        11'b110_0000_0101,   // R5 frame received polls transmit only
        11'b111_0000_1000,   // R5 disable blocks frame poll
        11'b100_0000_1000,   // R5 transmit off blocks frame poll
        11'b110_0111_0100,   // R5 everything owned
        11'b110_0111_0000    // R6 demand with everything owned
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 3:       return "R3";
            1, 2:       return "R4";
            4, 5, 10:   return "R6";
            default:    return "R5";
        endcase
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(rd_req == 1'b0, "R11", "rd_req in reset", rd_req, 0);
        chk(rx_w1 == '0 && rx_w0 == '0 && tx_w1 == '0 && tx_w0 == '0, "R11",
            "stored words in reset", rx_w1 | rx_w0 | tx_w1 | tx_w0, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        for (int i = 0; i < 11; i++) begin
            logic [10:0] v = VEC[i];
            @(negedge clk);
            rx_en = v[10]; tx_en = v[9]; tx_poll_dis = v[8]; ring_single = v[7];
            set_own(v[6], v[5], v[4]);
            base = nlog;
            case (v[3:2])
                2'd0: poll_demand = 1'b1;
                2'd1: rx_frame_done = 1'b1;
                default: tx_frame_done = 1'b1;
            endcase
            @(negedge clk) begin poll_demand = 1'b0; rx_frame_done = 1'b0; tx_frame_done = 1'b0; end
            repeat (16) @(negedge clk);
            chk_seq(base, v[1], v[0], vec_req(i));
        end

        // R2 busy channel holds a demand until it clears
        rx_en = 1; tx_en = 1; tx_poll_dis = 0; ring_single = 0;
        set_own(0, 0, 0);
        chan_busy = 1'b1;
        base = nlog;
        pulse_demand();
        repeat (12) @(negedge clk);
        chk(nlog == base, "R2", "reads while busy", nlog - base, 0);
        chan_busy = 1'b0;
        repeat (16) @(negedge clk);
        chk_seq(base, 1, 1, "R2");

        // R7 demand during a poll is serviced afterwards
        base = nlog;
        pulse_demand();
        while (!rd_req) @(negedge clk);
        pulse_demand();
        repeat (40) @(negedge clk);
        chk(nlog - base == 8, "R7", "reads for two demands", nlog - base, 8);

        // R10 capture only owned descriptors (bit 31 of the high word)
        mem_w[0] = 32'h8000_1234; mem_w[1] = 32'h5555_0001;
        mem_w[2] = 32'h0000_7777; mem_w[3] = 32'h0000_0001;
        pulse_demand();
        repeat (16) @(negedge clk);
        chk(rx_w1 == 32'h8000_1234, "R10", "owned rx high word", rx_w1, 32'h8000_1234);
        chk(rx_w0 == 32'h5555_0001, "R10", "owned rx low word", rx_w0, 32'h5555_0001);
        chk(tx_w1 == '0, "R10", "unowned tx high word kept", tx_w1, 0);
        mem_w[0] = 32'h0000_9999; mem_w[1] = 32'h0000_0002;
        pulse_demand();
        repeat (16) @(negedge clk);
        chk(rx_w1 == 32'h8000_1234, "R10", "unowned rx discarded", rx_w1, 32'h8000_1234);
        chk(rx_w0 == 32'h5555_0001, "R10", "unowned rx low discarded", rx_w0, 32'h5555_0001);
        mem_w = '{default: '0};

        // R8 default interval
        measure_interval(65536, "R8");
        // R9 write in the window takes effect
        pulse_cfg(0); pulse_cfg(1); write_ivl(16'd40); pulse_cfg(2);
        measure_interval(40, "R9");
        // R9 write after start is ignored
        write_ivl(16'd10);
        measure_interval(40, "R9");
        // R9 write before init done is ignored
        pulse_cfg(0); write_ivl(16'd7); pulse_cfg(1); pulse_cfg(2);
        measure_interval(40, "R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule